// File: doc/BRIEF.md
# Float to Packed BCD Converter

This block turns an IEEE double-precision number into an 18-digit signed decimal integer packed two digits per byte into an 80-bit word. The input is first rounded to an integer under one of four rounding modes chosen by a 2-bit field. The rounded magnitude is then checked against the largest 18-digit value. Status outputs report an invalid operation, an inexact (precision) result and the direction in which an inexact result moved.

A request is accepted with a valid/ready handshake. The block then runs a serial shift-and-add-3 loop for one iteration per magnitude bit. It raises `done` for a single cycle when the packed result and flags are final. The result and flags stay unchanged until the next request is accepted. Each request carries its own rounding mode, so a caller can mix modes from one conversion to the next.

Top module: `fp_bcd_conv`

## Requirements
- R1: `start_ready` is 1 only while the block is idle. A request is taken on a rising edge where `start_valid` and `start_ready` are both 1, and `start_ready` is then 0 until `done` has been raised. A `start_valid` asserted while busy has no effect on the result of the conversion in flight.
- R2: `done` is 1 for exactly one cycle. That cycle starts at the 64th rising edge after the edge that accepted the request.
- R3: In a valid result, bit 79 holds the input sign, bits 78:72 are 0, and bits 71:0 hold 18 decimal digits, four bits each. The least significant digit is in bits 3:0, and every digit nibble is in the range 0 to 9.
- R4: `round_mode` is sampled with the request. 00 rounds to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity and 11 rounds toward zero. The digits equal the magnitude of the rounded value.
- R5: An input whose exponent field (bits 62:52) is all ones, meaning a NaN or an infinity, sets `inv_flag`.
- R6: A rounded magnitude above 999,999,999,999,999,999 sets `inv_flag`. This includes every input with magnitude of at least 2^63.
- R7: When `inv_flag` is 1, `bcd_out` is FFC0 in hex followed by 64 zero bits, and both `prec_flag` and `rnd_up` are 0.
- R8: For a valid result, `prec_flag` is 1 exactly when the input was not an integer.
- R9: `rnd_up` is 1 exactly when `prec_flag` is 1 and the signed rounded result is greater than the input. It is 0 in every other case.
- R10: After reset, `start_ready` is 1, `done` is 0, `bcd_out` is all zero and both flags are 0.
- R11: While idle with no request, `bcd_out` and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request strobe |
| start_ready | output | 1 | Block idle and able to take a request |
| fp_in | input | 64 | Double-precision operand |
| round_mode | input | 2 | Rounding mode for this request |
| done | output | 1 | One-cycle completion pulse |
| bcd_out | output | 80 | Packed signed decimal result |
| inv_flag | output | 1 | Invalid operation |
| prec_flag | output | 1 | Result is inexact |
| rnd_up | output | 1 | Inexact result was rounded upward |

## Verification
A wrong iteration counter shows at the ports as `done` arriving one or more cycles early or late. The bench measures this latency on every request. A wrong add-3 correction or a dropped shift bit corrupts one or more digit nibbles, and this is seen at the next `done` as a mismatch against a reference built from real arithmetic and repeated division by ten. Flag registers that are loaded with the wrong sign or rounding increment show up in the same result cycle as a wrong `rnd_up` or `prec_flag`. Negative ties and negative inexact inputs are driven in every mode to expose this.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  // Largest magnitude representable with the given number of decimal digits.
  function automatic logic [63:0] max_mag(input int digits);
    logic [63:0] v;
    v = 64'd1;
    for (int i = 0; i < digits; i++) v = v * 64'd10;
    return v - 64'd1;
  endfunction
endpackage

// File: rtl/fbc_round.sv
module fbc_round
  import fbc_pkg::*;
#(
  parameter int DIGITS = 18,
  parameter int MAG_W  = 64
) (
  input  logic [63:0]      fp,
  input  logic [1:0]       rm,
  output logic [MAG_W-1:0] mag,
  output logic             sign,
  output logic             inv,
  output logic             inexact,
  output logic             up
);
  localparam logic [MAG_W-1:0] LIMIT = MAG_W'(max_mag(DIGITS));

  logic [10:0]        ex;
  logic [52:0]        sig;
  logic signed [12:0] unb;
  logic signed [12:0] sh;
  logic [127:0]       fx;
  logic               tiny, huge, special;
  logic               g, st, inc, loss;
  logic [MAG_W-1:0]   ipart;

  always_comb begin
    ex      = fp[62:52];
    sig     = {|ex, fp[51:0]};
    sign    = fp[63];
    unb     = $signed({2'b00, ex}) - 13'sd1023;
    sh      = unb + 13'sd12;
    special = &ex;
    huge    = (unb > 13'sd62);
    tiny    = (unb < -13'sd12);
    fx      = '0;
    if (!huge && !tiny) fx = {75'd0, sig} << sh[6:0];
    ipart = MAG_W'(fx[127:64]);
    g     = tiny ? 1'b0 : fx[63];
    st    = tiny ? |sig : |fx[62:0];
    loss  = g | st;
    unique case (rmode_e'(rm))
      RM_NEAR: inc = g & (st | ipart[0]);
      RM_DOWN: inc = sign & loss;
      RM_UP:   inc = ~sign & loss;
      default: inc = 1'b0;
    endcase
    mag     = ipart + MAG_W'(inc);
    inv     = special | huge | (mag > LIMIT);
    inexact = loss & ~inv;
    up      = inexact & (inc ^ sign);
  end
endmodule

// File: rtl/fbc_dabble.sv
module fbc_dabble #(
  parameter int DIGITS = 18,
  parameter int MAG_W  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [MAG_W-1:0]    bin_in,
  output logic [4*DIGITS-1:0] digits
);
  localparam int DIG_W = 4 * DIGITS;

  logic [MAG_W-1:0] bin_q, bin_d;
  logic [DIG_W-1:0] bcd_q, bcd_d, adj;

  for (genvar i = 0; i < DIGITS; i++) begin : g_adj
    assign adj[4*i +: 4] = (bcd_q[4*i +: 4] >= 4'd5) ? bcd_q[4*i +: 4] + 4'd3
                                                     : bcd_q[4*i +: 4];
  end

  always_comb begin
    bin_d = bin_q;
    bcd_d = bcd_q;
    if (load) begin
      bin_d = bin_in;
      bcd_d = '0;
    end else if (step) begin
      bcd_d = {adj[DIG_W-2:0], bin_q[MAG_W-1]};
      bin_d = bin_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      bcd_q <= '0;
    end else if (load || step) begin
      bin_q <= bin_d;
      bcd_q <= bcd_d;
    end
  end

  assign digits = bcd_q;

  for (genvar i = 0; i < DIGITS; i++) begin : g_chk
    // R3: every digit nibble stays decimal after each iteration
    a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (bcd_q[4*i +: 4] <= 4'd9));
  end
endmodule

// File: rtl/fp_bcd_conv.sv
module fp_bcd_conv
  import fbc_pkg::*;
#(
  parameter int DIGITS = 18,
  parameter int MAG_W  = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_valid,
  output logic                          start_ready,
  input  logic [63:0]                   fp_in,
  input  logic [1:0]                    round_mode,
  output logic                          done,
  output logic [8*(DIGITS/2+1)-1:0]     bcd_out,
  output logic                          inv_flag,
  output logic                          prec_flag,
  output logic                          rnd_up
);
  localparam int BCD_W = 8 * (DIGITS / 2 + 1);
  localparam int DIG_W = 4 * DIGITS;
  localparam int PAD_W = BCD_W - 1 - DIG_W;
  localparam int CNT_W = $clog2(MAG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAG_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic             r_sign, r_inv, r_inexact, r_up;
  logic [MAG_W-1:0] r_mag;
  logic             sign_q, inv_q, prec_q, up_q;
  logic [DIG_W-1:0] digits;

  fbc_round #(.DIGITS(DIGITS), .MAG_W(MAG_W)) u_round (
    .fp(fp_in), .rm(round_mode), .mag(r_mag), .sign(r_sign),
    .inv(r_inv), .inexact(r_inexact), .up(r_up)
  );

  fbc_dabble #(.DIGITS(DIGITS), .MAG_W(MAG_W)) u_dabble (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(state_q == ST_RUN),
    .bin_in(r_mag), .digits(digits)
  );

  assign accept = start_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      inv_q  <= 1'b0;
      prec_q <= 1'b0;
      up_q   <= 1'b0;
    end else if (accept) begin
      sign_q <= r_sign;
      inv_q  <= r_inv;
      prec_q <= r_inexact;
      up_q   <= r_up;
    end
  end

  assign start_ready = (state_q == ST_IDLE);
  assign done        = (state_q == ST_FIN);
  assign inv_flag    = inv_q;
  assign prec_flag   = prec_q;
  assign rnd_up      = up_q;
  assign bcd_out     = inv_q ? {8'hFF, 8'hC0, {(BCD_W-16){1'b0}}}
                             : {sign_q, {PAD_W{1'b0}}, digits};

  // R1: taking a request makes the block busy
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> !start_ready);
  // R2: completion is a single-cycle pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: completion only follows the iteration phase
  a_r2_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state_q == ST_RUN));
  // R7: an invalid result carries no precision status
  a_r7_inv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    inv_flag |-> !prec_flag && !rnd_up);
  // R9: round direction only reported with an inexact result
  a_r9_up_needs_prec: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_up |-> prec_flag);
  // R11: idle without request keeps the result
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready && !start_valid |=> $stable(bcd_out) && $stable(inv_flag)
                                    && $stable(prec_flag) && $stable(rnd_up));
endmodule

// File: tb/fp_bcd_conv_test.sv
`timescale 1ns/1ps
module fp_bcd_conv_test;
  logic        clk, rst_n, start_valid, start_ready, done;
  logic [63:0] fp_in;
  logic [1:0]  round_mode;
  logic [79:0] bcd_out;
  logic        inv_flag, prec_flag, rnd_up;

  int n_tests = 0;
  int n_fail  = 0;

  fp_bcd_conv uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .fp_in(fp_in), .round_mode(round_mode), .done(done), .bcd_out(bcd_out),
    .inv_flag(inv_flag), .prec_flag(prec_flag), .rnd_up(rnd_up)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [79:0] act,
                       input logic [79:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference built from real arithmetic and decimal division.
  task automatic model(input logic [63:0] x, input logic [1:0] rm,
                       output logic [79:0] b, output logic inv, output logic prec,
                       output logic up);
    real a, fl, f;
    logic [63:0] ip, m;
    logic s, inc, nx;
    s = x[63];
    b = '0; inv = 1'b0; prec = 1'b0; up = 1'b0;
    if (&x[62:52]) inv = 1'b1;
    else begin
      a = $bitstoreal({1'b0, x[62:0]});
      if (a >= 9223372036854775808.0) inv = 1'b1;
      else begin
        fl = $floor(a);
        f  = a - fl;
        ip = 64'(longint'(fl));
        nx = (f != 0.0);
        case (rm)
          2'b00:   inc = (f > 0.5) || (f == 0.5 && ip[0]);
          2'b01:   inc = s && nx;
          2'b10:   inc = !s && nx;
          default: inc = 1'b0;
        endcase
        m = ip + 64'(inc);
        if (m > 64'd999999999999999999) inv = 1'b1;
        else begin
          for (int i = 0; i < 18; i++) begin
            b[4*i +: 4] = 4'(m % 64'd10);
            m = m / 64'd10;
          end
          b[79] = s;
          prec  = nx;
          up    = nx && (inc ^ s);
        end
      end
    end
    if (inv) b = {16'hFFC0, 64'd0};
  endtask

  task automatic run(input logic [63:0] x, input logic [1:0] rm, input bit inject);
    logic [79:0] eb, hold;
    logic ei, ep, eu;
    int k;
    model(x, rm, eb, ei, ep, eu);
    @(negedge clk);
    check(start_ready === 1'b1, "R1 ready when idle", 80'(start_ready), 80'd1);
    start_valid = 1'b1; fp_in = x; round_mode = rm;
    @(negedge clk);
    start_valid = 1'b0;
    check(start_ready === 1'b0, "R1 busy after accept", 80'(start_ready), 80'd0);
    k = 0;
    while (done !== 1'b1 && k < 200) begin
      if (inject && k == 4) begin
        start_valid = 1'b1; fp_in = ~x; round_mode = ~rm;
      end
      if (inject && k == 14) start_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    check(k == 64, "R2 done latency", 80'(k), 80'd64);
    if (ei) begin
      check(inv_flag === 1'b1, (&x[62:52]) ? "R5 nan/inf invalid" : "R6 range invalid",
            80'(inv_flag), 80'd1);
      check(bcd_out === eb && prec_flag === 1'b0 && rnd_up === 1'b0,
            "R7 indefinite pattern", bcd_out, eb);
    end else begin
      check(inv_flag === 1'b0, "R6 in range", 80'(inv_flag), 80'd0);
      check(bcd_out === eb, inject ? "R1 busy request ignored" : "R3/R4 packed digits",
            bcd_out, eb);
      check(prec_flag === ep, "R8 precision", 80'(prec_flag), 80'(ep));
      check(rnd_up === eu, "R9 round up", 80'(rnd_up), 80'(eu));
    end
    hold = bcd_out;
    @(negedge clk);
    check(done === 1'b0, "R2 single pulse", 80'(done), 80'd0);
    repeat (2) @(negedge clk);
    check(bcd_out === hold, "R11 hold while idle", bcd_out, hold);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] dir [13];
    logic [63:0] x;
    void'($urandom(32'd20240611));
    dir[0]  = 64'h3FE0000000000000; // 0.5
    dir[1]  = 64'h3FF8000000000000; // 1.5
    dir[2]  = 64'h4004000000000000; // 2.5
    dir[3]  = 64'hC004000000000000; // -2.5
    dir[4]  = 64'hBFD3333333333333; // -0.3
    dir[5]  = 64'h7FF8000000000000; // NaN
    dir[6]  = 64'hFFF0000000000000; // -inf
    dir[7]  = 64'h43ABC16D674EC800; // 1e18
    dir[8]  = 64'h43ABC16D674EC7FF; // 1e18-128
    dir[9]  = 64'h43E0000000000000; // 2^63
    dir[10] = 64'h8000000000000000; // -0
    dir[11] = 64'h0000000000000001; // smallest denormal
    dir[12] = 64'hC00E000000000000; // -3.75
    start_valid = 1'b0; fp_in = '0; round_mode = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_ready === 1'b1 && done === 1'b0, "R10 reset handshake",
          80'({start_ready, done}), 80'b10);
    check(bcd_out === 80'd0 && inv_flag === 1'b0 && prec_flag === 1'b0 && rnd_up === 1'b0,
          "R10 reset result", bcd_out, 80'd0);
    for (int i = 0; i < 13; i++)
      for (int r = 0; r < 4; r++) run(dir[i], 2'(r), 1'b0);
    for (int i = 0; i < 60; i++) begin
      x[63]    = 1'($urandom);
      x[62:52] = 11'(1020 + ($urandom % 70));
      x[51:0]  = {20'($urandom), $urandom};
      if (i % 5 == 0) x[30:0] = '0;
      run(x, 2'($urandom), (i % 7) == 3);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule